// File: doc/BRIEF.md
# Controller Clock Divider with Band-Based Ratio Picker

This block makes a slower controller clock out of a fast coprocessor clock. A three-bit select picks one of eight fixed division ratios. Some of those ratios are not powers of two. Every ratio above one is even, so the divided clock is always a 50% duty square wave. A ratio of one passes the input clock straight through. The block also emits a one-cycle tick in the input clock domain at every rising edge of the divided clock. Logic that stays on the fast clock uses this tick as a clock enable.

An active-high divider reset freezes the divider at the start of a period. A clock enable forces both the output clock and the tick low. A bypass select replaces the divided clock with a clock taken from an external pin. When the select changes while the divider runs, the new ratio waits for the current period to end, so no shortened pulse appears.

A separate combinational picker takes the input frequency in kHz. It returns the lowest select code whose truncated output frequency lies in a permitted band. If no code qualifies, it raises an error flag.

Top module: `ctrl_clk_divider`

## Requirements
- R1: Select codes 0,1,2,3,4,5,6,7 give division ratios 1,2,4,6,8,16,24,32. In steady running, `tick_o` is high for one `clk_i` cycle in every ratio cycles.
- R2: While `div_rst_i` is high, `tick_o` stays low and the divided clock stays low. The first tick comes in the first `clk_i` cycle after `div_rst_i` is sampled low.
- R3: While `clk_en_i` is low, `ctrl_clk_o` and `tick_o` are both held low.
- R4: With `byp_sel_i`=1 and the enable high, `ctrl_clk_o` follows `pin_clk_i`. With `byp_sel_i`=0, it carries the divided clock.
- R5: The picker returns on `auto_sel_o` the lowest code whose value floor(freq_khz_i / ratio) lies in [150000, 300000], both limits included.
- R6: When no code meets the R5 band, `auto_err_o` is 1 and `auto_sel_o` is 0. Otherwise `auto_err_o` is 0.
- R7: A select change made partway through a period does not affect that period. The period completes at the old ratio, and the next one uses the new ratio.
- R8: For ratios above 1, the divided clock is high for ratio/2 `clk_i` cycles. The high phase starts at the cycle where `tick_o` is high. For ratio 1, the output equals `clk_i`.
- R9: While `rst_n` is low (synchronous, active low), `tick_o` and `ctrl_clk_o` stay low. The divider then starts exactly as it does after the divider reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast coprocessor clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| div_rst_i | input | 1 | Active-high divider hold |
| clk_en_i | input | 1 | Output clock and tick enable |
| byp_sel_i | input | 1 | 0 selects the divided clock, 1 selects the pin clock |
| pin_clk_i | input | 1 | External pin clock for bypass |
| ratio_sel_i | input | 3 | Division ratio select code |
| freq_khz_i | input | 24 | Input frequency in kHz, used by the picker |
| ctrl_clk_o | output | 1 | Controller clock out |
| tick_o | output | 1 | One-cycle strobe at each divided rising edge |
| auto_sel_o | output | 3 | Picker result code |
| auto_err_o | output | 1 | Picker found no ratio in the band |

## Verification
The hardest case to reach is a select change that lands in the middle of a running period. From the ports, the bench can only see it as tick spacing. The bench first locks onto a tick at ratio 8. It waits two cycles and then switches the select to ratio 4. It expects six more cycles to the next tick, which completes the old period, and then a 4-cycle spacing. The picker is also driven at frequencies one kHz past each band edge, where the floor in the division decides the result.

// File: rtl/ccd_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the select-to-ratio mapping for the divider.
// Assumes the ratio table is fixed in hardware; only its encoding width is exported.
package ccd_pkg;
    localparam int SEL_W     = 3;
    localparam int NUM_SEL   = 1 << SEL_W;
    localparam int MAX_RATIO = 32;
    localparam int CNT_W     = $clog2(MAX_RATIO);

    // Maps a select code onto its division ratio.
    function automatic logic [CNT_W:0] ratio_of(input logic [SEL_W-1:0] code);
        case (code)
            3'd0:    ratio_of = (CNT_W+1)'(1);
            3'd1:    ratio_of = (CNT_W+1)'(2);
            3'd2:    ratio_of = (CNT_W+1)'(4);
            3'd3:    ratio_of = (CNT_W+1)'(6);
            3'd4:    ratio_of = (CNT_W+1)'(8);
            3'd5:    ratio_of = (CNT_W+1)'(16);
            3'd6:    ratio_of = (CNT_W+1)'(24);
            default: ratio_of = (CNT_W+1)'(32);
        endcase
    endfunction
endpackage

// File: rtl/ccd_ratio_counter.sv
`timescale 1ns/1ps
// Module: period counter for the divider.
// It counts 0..ratio-1 and loads a new ratio only at a wrap, during a hold,
// or at the start of a run. Assumes hold_i and sel_i are synchronous to clk_i.
module ccd_ratio_counter
    import ccd_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             run_o,
    output logic             phase_o,
    output logic             ratio_one_o,
    output logic             tick_raw_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] act_q;
    logic             run_q;
    logic [CNT_W:0]   ratio;
    logic             wrap;

    // Decode the active ratio and detect the last count of the period.
    always_comb begin
        ratio = ratio_of(act_q);
        wrap  = ({1'b0, cnt_q} == ratio - 1'b1);
    end

    // Advance the counter; load a new ratio only at period boundaries.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
            run_q <= 1'b0;
        end else if (hold_i) begin
            cnt_q <= '0;
            act_q <= sel_i;
            run_q <= 1'b0;
        end else if (!run_q) begin
            cnt_q <= '0;
            act_q <= sel_i;
            run_q <= 1'b1;
        end else if (wrap) begin
            cnt_q <= '0;
            act_q <= sel_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Derive the half-period phase and the period-start strobe.
    always_comb begin
        ratio_one_o = (ratio == (CNT_W+1)'(1));
        run_o       = run_q;
        phase_o     = run_q && !ratio_one_o && ({1'b0, cnt_q} < (ratio >> 1));
        tick_raw_o  = run_q && (cnt_q == '0);
    end

    // The count never leaves the range of the active ratio.
    assert_count_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
        ({1'b0, cnt_q} < ratio));

    // A hold suppresses the strobe in the following cycle.
    assert_hold_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
        hold_i |=> !tick_raw_o);

    // The active ratio only ever changes when the count restarts.
    assert_switch_at_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
        !$stable(act_q) |-> (cnt_q == '0));
endmodule

// File: rtl/ccd_band_picker.sv
`timescale 1ns/1ps
// Module: combinational ratio picker.
// It returns the lowest select code whose truncated output frequency lies in
// [BAND_LO, BAND_HI] kHz. Assumes freq_i is given in kHz.
module ccd_band_picker
    import ccd_pkg::*;
#(
    parameter int FREQ_W  = 24,
    parameter int BAND_LO = 150000,
    parameter int BAND_HI = 300000
) (
    input  logic [FREQ_W-1:0] freq_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic              err_o
);
    localparam int PROD_W = FREQ_W + CNT_W + 2;
    localparam logic [PROD_W-1:0] LO_P = PROD_W'(BAND_LO);
    localparam logic [PROD_W-1:0] HI_P = PROD_W'(BAND_HI);

    logic [PROD_W-1:0]  freq_w;
    logic [NUM_SEL-1:0] fits;

    assign freq_w = PROD_W'(freq_i);

    // Per-ratio band test, using multiplied limits in place of a divider.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_fit
        logic [PROD_W-1:0] r_w;
        assign r_w     = PROD_W'(ratio_of(SEL_W'(g)));
        assign fits[g] = (freq_w >= LO_P * r_w) && (freq_w <= HI_P * r_w + r_w - 1'b1);
    end

    // Priority pick: the lowest qualifying index wins.
    always_comb begin
        sel_o = '0;
        err_o = 1'b1;
        for (int i = NUM_SEL - 1; i >= 0; i--) begin
            if (fits[i]) begin
                sel_o = SEL_W'(i);
                err_o = 1'b0;
            end
        end
    end

    // Cross-check the pick with a true division.
    always_comb begin
        if (!err_o) begin
            assert_band_R5: assert ((freq_w / PROD_W'(ratio_of(sel_o))) >= LO_P &&
                                    (freq_w / PROD_W'(ratio_of(sel_o))) <= HI_P);
        end
    end
endmodule

// File: rtl/ccd_out_mux.sv
`timescale 1ns/1ps
// Module: output stage.
// It picks between the divided clock and the pin clock, then applies the enable.
// Assumes the pin clock is already safe to switch to (no glitch-free handover).
module ccd_out_mux (
    input  logic clk_i,
    input  logic pin_clk_i,
    input  logic en_i,
    input  logic byp_i,
    input  logic run_i,
    input  logic ratio_one_i,
    input  logic phase_i,
    input  logic tick_raw_i,
    output logic clk_o,
    output logic tick_o
);
    logic div_clk;

    // Ratio 1 passes the input clock; otherwise use the registered phase.
    always_comb begin
        div_clk = ratio_one_i ? (run_i & clk_i) : phase_i;
        clk_o   = en_i & (byp_i ? pin_clk_i : div_clk);
        tick_o  = en_i & tick_raw_i;
    end
endmodule

// File: rtl/ctrl_clk_divider.sv
`timescale 1ns/1ps
// Module: top of the controller clock divider.
// It ties together the period counter, the output stage and the band picker.
// Assumes every control input is synchronous to clk_i.
module ctrl_clk_divider
    import ccd_pkg::*;
#(
    parameter int FREQ_W  = 24,
    parameter int BAND_LO = 150000,
    parameter int BAND_HI = 300000
) (
    input  logic              clk_i,
    input  logic              rst_n,
    input  logic              div_rst_i,
    input  logic              clk_en_i,
    input  logic              byp_sel_i,
    input  logic              pin_clk_i,
    input  logic [SEL_W-1:0]  ratio_sel_i,
    input  logic [FREQ_W-1:0] freq_khz_i,
    output logic              ctrl_clk_o,
    output logic              tick_o,
    output logic [SEL_W-1:0]  auto_sel_o,
    output logic              auto_err_o
);
    logic run, phase, ratio_one, tick_raw;

    ccd_ratio_counter u_cnt (
        .clk_i      (clk_i),
        .rst_n      (rst_n),
        .hold_i     (div_rst_i),
        .sel_i      (ratio_sel_i),
        .run_o      (run),
        .phase_o    (phase),
        .ratio_one_o(ratio_one),
        .tick_raw_o (tick_raw)
    );

    ccd_out_mux u_mux (
        .clk_i      (clk_i),
        .pin_clk_i  (pin_clk_i),
        .en_i       (clk_en_i),
        .byp_i      (byp_sel_i),
        .run_i      (run),
        .ratio_one_i(ratio_one),
        .phase_i    (phase),
        .tick_raw_i (tick_raw),
        .clk_o      (ctrl_clk_o),
        .tick_o     (tick_o)
    );

    ccd_band_picker #(.FREQ_W(FREQ_W), .BAND_LO(BAND_LO), .BAND_HI(BAND_HI)) u_pick (
        .freq_i(freq_khz_i),
        .sel_o (auto_sel_o),
        .err_o (auto_err_o)
    );
endmodule

// File: tb/test_ctrl_clk_divider.sv
`timescale 1ns/1ps
// Bench: a table walk over all select codes and picker frequencies,
// followed by directed tests for reset, enable, bypass and a mid-period switch.
module test_ctrl_clk_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_rst = 1'b0;
    logic        en = 1'b1;
    logic        byp = 1'b0;
    logic        pin = 1'b0;
    logic [2:0]  sel = 3'd0;
    logic [23:0] freq = '0;
    logic        cclk, tick, aerr;
    logic [2:0]  asel;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    ctrl_clk_divider i_ctrl_clk_divider (
        .clk_i(clk), .rst_n(rst_n), .div_rst_i(div_rst), .clk_en_i(en),
        .byp_sel_i(byp), .pin_clk_i(pin), .ratio_sel_i(sel), .freq_khz_i(freq),
        .ctrl_clk_o(cclk), .tick_o(tick), .auto_sel_o(asel), .auto_err_o(aerr)
    );

    localparam int RATIO_TAB [8] = '{1, 2, 4, 6, 8, 16, 24, 32};
    localparam int F_TAB   [10] = '{150000, 300000, 300001, 600001, 600002,
                                    100000, 149999, 5000000, 9000000, 16000000};
    localparam int PICK_TAB[10] = '{0, 0, 1, 1, 2, -1, -1, 6, 7, -1};

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance to the middle of the clock-high phase after the next edge.
    task automatic step();
        @(posedge clk);
        #5;
    endtask

    // Lock onto a tick, then measure the spacing to the next one and the high samples.
    task automatic measure(output int gap, output int hi);
        int guard = 0;
        while (!tick && guard < 200) begin step(); guard++; end
        gap = 0;
        hi = 0;
        do begin
            if (cclk) hi++;
            step();
            gap++;
        end while (!tick && gap < 200);
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int gap, hi, cnt;
        // R9: block reset keeps the outputs idle.
        for (int k = 0; k < 3; k++) begin
            step();
            check("R9 tick in reset", int'(tick), 0);
            check("R9 clk in reset", int'(cclk), 0);
        end
        @(negedge clk); rst_n = 1'b1;
        step();
        check("R9 first tick after reset", int'(tick), 1);

        // R1/R8/R2: table walk over all select codes.
        for (int s = 0; s < 8; s++) begin
            @(negedge clk); div_rst = 1'b1; sel = 3'(s);
            for (int k = 0; k < 3; k++) begin
                step();
                check("R2 no tick in hold", int'(tick), 0);
                check("R2 clk low in hold", int'(cclk), 0);
            end
            @(negedge clk); div_rst = 1'b0;
            step();
            check("R2 tick right after release", int'(tick), 1);
            measure(gap, hi);
            check("R1 tick spacing", gap, RATIO_TAB[s]);
            check("R8 high samples", hi, (RATIO_TAB[s] == 1) ? 1 : RATIO_TAB[s] / 2);
        end

        // R8: ratio 1 output follows the input clock low phase too.
        @(negedge clk); div_rst = 1'b1; sel = 3'd0;
        @(negedge clk); div_rst = 1'b0;
        step(); step();
        @(negedge clk); #5;
        check("R8 ratio1 low phase", int'(cclk), 0);

        // R7: switch from ratio 8 to ratio 4 two cycles into a period.
        @(negedge clk); div_rst = 1'b1; sel = 3'd4;
        @(negedge clk); div_rst = 1'b0;
        step();
        measure(gap, hi);
        step(); step();
        sel = 3'd2;
        cnt = 0;
        while (!tick && cnt < 100) begin step(); cnt++; end
        check("R7 old period completes", cnt, 6);
        measure(gap, hi);
        check("R7 new ratio after boundary", gap, 4);

        // R3: enable low silences clock and tick.
        en = 1'b0;
        for (int k = 0; k < 8; k++) begin
            step();
            check("R3 tick gated", int'(tick), 0);
            check("R3 clk gated", int'(cclk), 0);
        end
        en = 1'b1;

        // R4: bypass follows the pin clock.
        byp = 1'b1;
        for (int k = 0; k < 4; k++) begin
            pin = k[0];
            #1;
            check("R4 bypass follows pin", int'(cclk), k % 2);
        end
        byp = 1'b0; pin = 1'b0;
        measure(gap, hi);
        check("R4 divided path restored", gap, 4);

        // R5/R6: picker table.
        for (int v = 0; v < 10; v++) begin
            freq = 24'(F_TAB[v]);
            #1;
            if (PICK_TAB[v] < 0) begin
                check("R6 error flag", int'(aerr), 1);
                check("R6 code on error", int'(asel), 0);
            end else begin
                check("R6 no error", int'(aerr), 0);
                check("R5 picked code", int'(asel), PICK_TAB[v]);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule